// File: doc/BRIEF.md
# Debug Link Speed Probe

This block sits on the host end of a one-wire debug connection and learns how fast the target's debug clock runs. A start pulse makes it pull the shared open-drain wire low for a long interval. No normal debug traffic ever holds the wire low for that long, so the target reads the interval as a request to synchronise. The host then drives the wire high for a single clock to speed up the rising edge, and afterwards leaves the wire undriven.

The target answers with a low pulse that lasts exactly 128 of its own debug clocks. The host times that pulse in its own faster clock and publishes the result as a 16-bit count that saturates. The count divided by 128 gives host clocks per target bit clock. The host raises an error flag if no reply starts within a window, or if the reply stays low too long.

The wire is modelled as separate drive-enable and drive-value outputs plus a sampled input. The pin input passes through a synchroniser before it is used. There is no data stream at the edge of this block. Each start yields exactly one result, held on `count_o` until the next start is accepted, so there is no back-pressure to handle.

Top module: `sync_rate_meter`

## Requirements
- R1: After reset, busy_o, done_o, err_o, pin_oe_o and pin_out_o are 0 and count_o is 0.
- R2: A start_i sampled high while idle makes the block drive the wire low (pin_oe_o=1, pin_out_o=0) from the next cycle for exactly REQ_LEN consecutive cycles, with busy_o high.
- R3: The low request is followed by exactly one cycle of pin_oe_o=1, pin_out_o=1, after which pin_oe_o stays 0 until the next accepted start.
- R4: On success, count_o equals the number of host clock edges at which the reply held the wire low.
- R5: done_o rises SYNC_STAGES+1 cycles (3 by default) after the wire returns high, in the same cycle that busy_o falls. done_o and err_o are never high together, and both stay high until the next accepted start clears them.
- R6: A reply longer than 2^CNT_W-1 host cycles, but no longer than LOW_LIMIT, reports count_o = 2^CNT_W-1 with done_o and without wrapping.
- R7: If no falling edge is seen within WAIT_LIMIT cycles after release, err_o rises, busy_o falls and count_o is 0.
- R8: A reply that is low for more than LOW_LIMIT samples ends with err_o and count_o = 0. A reply of exactly LOW_LIMIT samples still completes with done_o.
- R9: start_i while busy_o is high is ignored: no new request is driven and exactly one result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, also the measuring clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sync request (taken only when idle) |
| pin_in_i | input | 1 | Level seen on the debug wire |
| busy_o | output | 1 | A request or measurement is in progress |
| done_o | output | 1 | Last run measured a reply (held until next start) |
| err_o | output | 1 | Last run timed out (held until next start) |
| count_o | output | CNT_W | Measured low time of the reply in host clocks |
| pin_oe_o | output | 1 | Drive enable for the debug wire |
| pin_out_o | output | 1 | Value driven when pin_oe_o is high |

## Verification
The wire request is due one cycle after start_i is sampled. The bench measures its length and the single high cycle at every falling clock edge. The result flags are due three clock edges after the bench's target model releases the wire. The bench records the edge count at release and checks that done_o rises exactly three edges later, against an expected item queued when the stimulus was issued. Error outcomes are compared only for their flag and zeroed count, because their timing depends on the timeout windows.

// File: rtl/sync_meter_pkg.sv
package sync_meter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_KICK,
    ST_WAIT,
    ST_MEAS
  } meter_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_o
);
  // one extra stage beyond the synchroniser keeps the previous level
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SH_W-2:0], pin_i};
  end

  assign lvl_o  = sh[SYNC_STAGES-1];
  assign fall_o = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         one_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    val_o <= '0;
    else if (clr_i)                val_o <= '0;
    else if (one_i)                val_o <= W'(1);
    else if (inc_i && val_o != TOP) val_o <= val_o + W'(1);
  end

  assert_hold_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (val_o == TOP && inc_i && !clr_i && !one_i) |=> (val_o == TOP));
endmodule

// File: rtl/sync_seq.sv
module sync_seq
  import sync_meter_pkg::*;
#(
  parameter int REQ_LEN    = 256,
  parameter int WAIT_LIMIT = 4096,
  parameter int LOW_LIMIT  = 65535,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             lvl_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  output logic             cnt_clr_o,
  output logic             cnt_one_o,
  output logic             cnt_inc_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pin_oe_o,
  output logic             pin_out_o
);
  localparam int unsigned TMR_MAX = max3(REQ_LEN, WAIT_LIMIT, LOW_LIMIT);
  localparam int          TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] REQ_END  = TMR_W'(REQ_LEN - 1);
  localparam logic [TMR_W-1:0] WAIT_END = TMR_W'(WAIT_LIMIT - 1);
  localparam logic [TMR_W-1:0] LOW_END  = TMR_W'(LOW_LIMIT);

  meter_state_e     state;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      count_o <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          state  <= ST_REQ;
          tmr    <= '0;
          done_o <= 1'b0;
          err_o  <= 1'b0;
        end
        ST_REQ: begin
          if (tmr == REQ_END) begin
            state <= ST_KICK;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_KICK: begin
          state <= ST_WAIT;
          tmr   <= '0;
        end
        ST_WAIT: begin
          if (fall_i) begin
            state <= ST_MEAS;
            tmr   <= TMR_W'(1);
          end else if (tmr == WAIT_END) begin
            state   <= ST_IDLE;
            err_o   <= 1'b1;
            count_o <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_MEAS: begin
          if (lvl_i) begin
            state   <= ST_IDLE;
            done_o  <= 1'b1;
            count_o <= cnt_val_i;
          end else if (tmr == LOW_END) begin
            state   <= ST_IDLE;       // over-long reply, R8
            err_o   <= 1'b1;
            count_o <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_clr_o = (state == ST_IDLE) && start_i;
    cnt_one_o = (state == ST_WAIT) && fall_i;
    cnt_inc_o = (state == ST_MEAS) && !lvl_i;
    busy_o    = (state != ST_IDLE);
    pin_oe_o  = (state == ST_REQ) || (state == ST_KICK);
    pin_out_o = (state == ST_KICK);
  end

  assert_req_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_i) |=> (pin_oe_o && !pin_out_o));

  assert_kick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o && pin_out_o) |=> !pin_oe_o);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // covers both timeout kinds (R7 and R8)
  assert_fail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (count_o == '0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT || state == ST_MEAS) && start_i) |=> (state != ST_REQ));
endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter #(
  parameter int REQ_LEN     = 256,
  parameter int WAIT_LIMIT  = 4096,
  parameter int LOW_LIMIT   = 65535,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pin_in_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pin_oe_o,
  output logic             pin_out_o
);
  logic             lvl, fall;
  logic             cnt_clr, cnt_one, cnt_inc;
  logic [CNT_W-1:0] cnt_val;

  pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in_i), .lvl_o(lvl), .fall_o(fall)
  );

  sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .one_i(cnt_one),
    .inc_i(cnt_inc), .val_o(cnt_val)
  );

  sync_seq #(
    .REQ_LEN(REQ_LEN), .WAIT_LIMIT(WAIT_LIMIT),
    .LOW_LIMIT(LOW_LIMIT), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lvl_i(lvl), .fall_i(fall),
    .cnt_val_i(cnt_val), .cnt_clr_o(cnt_clr), .cnt_one_o(cnt_one),
    .cnt_inc_o(cnt_inc), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .count_o(count_o), .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o)
  );
endmodule

// File: tb/sync_rate_meter_test.sv
module sync_rate_meter_test;
  localparam int CLK_PERIOD = 10;
  localparam int REQ_LEN    = 20;
  localparam int WAIT_LIMIT = 60;
  localparam int LOW_LIMIT  = 400;
  localparam int CNT_W      = 8;
  localparam int SAT        = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tgt_low = 1'b0;
  logic pin;
  logic busy, done, err, oe, dout;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rel_cyc = 0;
  int low_run = 0;
  int kick_run = 0;
  bit prev_flag = 1'b0;
  bit finished = 1'b0;

  typedef struct { bit is_err; int cnt; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign pin = oe ? dout : !tgt_low;

  sync_rate_meter #(
    .REQ_LEN(REQ_LEN), .WAIT_LIMIT(WAIT_LIMIT), .LOW_LIMIT(LOW_LIMIT),
    .CNT_W(CNT_W), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pin_in_i(pin),
    .busy_o(busy), .done_o(done), .err_o(err), .count_o(count),
    .pin_oe_o(oe), .pin_out_o(dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // wire-shape monitor: request length, kick width, release (R2, R3)
  always @(negedge clk) if (rst_n) begin
    if (oe && !dout) low_run++;
    else if (oe && dout) begin
      check(low_run == REQ_LEN, "R2 request length", low_run, REQ_LEN);
      low_run = 0;
      kick_run++;
    end else if (kick_run > 0) begin
      check(kick_run == 1, "R3 speedup width", kick_run, 1);
      kick_run = 0;
    end
    if (tgt_low && oe) check(1'b0, "R3 host drives during reply", 1, 0);
  end

  // scoreboard monitor (R4..R9)
  always @(negedge clk) if (rst_n) begin
    if ((done || err) && !prev_flag) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected extra result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(err == e.is_err, "R7 R8 error flag", int'(err), int'(e.is_err));
        check(int'(count) == e.cnt, "R4 R6 count", int'(count), e.cnt);
        check(!busy, "R5 busy falls with flag", int'(busy), 0);
        check(!(done && err), "R5 flags exclusive", int'(done && err), 0);
        if (!e.is_err)
          check(cyc == rel_cyc + 3, "R5 done latency", cyc - rel_cyc, 3);
      end
    end
    prev_flag = done || err;
  end

  task automatic run_case(input int delay, input int low_len, input bit expect_err,
                          input int exp_cnt, input bit extra_start);
    exp_t e;
    e.is_err = expect_err;
    e.cnt    = exp_cnt;
    exp_q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy && !done && !err, "R5 flags cleared by start", int'({busy, done, err}), 4);
    while (!(oe && dout)) @(negedge clk);
    @(negedge clk);
    if (low_len > 0) begin
      repeat (delay) @(negedge clk);
      tgt_low = 1'b1;
      for (int i = 0; i < low_len; i++) begin
        start = extra_start && (i == low_len / 2);
        @(negedge clk);
      end
      start = 1'b0;
      tgt_low = 1'b0;
      rel_cyc = cyc;
    end
    while (!(done || err)) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done == !expect_err && err == expect_err, "R5 flags held",
          int'({done, err}), expect_err ? 1 : 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !oe && !dout && count == 0, "R1 reset state",
          int'({busy, done, err, oe, dout}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(16, 128, 1'b0, 128, 1'b0);           // R4 nominal reply
    run_case(3, 37, 1'b0, 37, 1'b0);              // R4 other length
    run_case(0, 1, 1'b0, 1, 1'b0);                // R4 shortest reply
    run_case(10, 300, 1'b0, SAT, 1'b0);           // R6 saturation
    run_case(5, LOW_LIMIT, 1'b0, SAT, 1'b0);      // R8 boundary passes
    run_case(5, LOW_LIMIT + 1, 1'b1, 0, 1'b0);    // R8 over-long reply
    run_case(0, 0, 1'b1, 0, 1'b0);                // R7 no reply
    run_case(WAIT_LIMIT + 10, 10, 1'b1, 0, 1'b0); // R7 late reply
    run_case(4, 50, 1'b0, 50, 1'b1);              // R9 start while busy
    repeat (WAIT_LIMIT + REQ_LEN + 20) @(negedge clk);
    check(exp_q.size() == 0 && !busy, "R9 no pending or extra run", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule